// File: doc/BRIEF.md
# Windowed core access arbiter

This block connects a host register-access port to a backplane on which several cores share one address window. Only one core is visible through the window at a time. The window is selected by writing a base address into a window register that sits outside the block. For each host request the block compares the target core with the core it last mapped. If they match, it goes straight to the backplane access. If they differ, it programs the window register and reads it back to confirm the switch. When the read-back disagrees, it waits a fixed time and programs the register again.

Once the window is confirmed, the block performs one 8-, 16- or 32-bit access through the window and returns a single response. If the switch never succeeds, or if the backplane is unpowered when the request arrives, the access does not happen. In that case a read returns all ones at its width and a write is discarded. Both cases raise an error flag. Only one request is in flight at any time.

Top module: `core_window_arbiter`

## Requirements
- R1: Every window register write carries `ENUM_BASE + core * CORE_SPAN` for the core of the current request.
- R2: After reset no core is recorded as mapped, so the first powered request always issues at least one window write before it touches the backplane.
- R3: A request for the recorded core issues no window write. A successful switch records the new target as the mapped core.
- R4: The read-back value is decoded as `(value - ENUM_BASE) / CORE_SPAN`, with the division truncated. A value below `ENUM_BASE` counts as a mismatch. The backplane access (`bus_req`) is issued only after a decoded read-back equal to the target.
- R5: After a mismatch the block waits `CLK_MHZ * WAIT_US` cycles and then writes the window again. Consecutive window writes within one request are therefore exactly `CLK_MHZ * WAIT_US + 2` cycles apart.
- R6: A request issues at most `MAX_RETRY + 2` window writes. A mismatch on the last of them ends the request with `rsp_err = 1` and leaves no core recorded as mapped. With exactly `MAX_RETRY + 1` bad read-backs, the final write still succeeds.
- R7: A read that fails returns ones in the low bits of its width and zeros above them. The size code is 0 for 8 bits, 1 for 16 bits, and 2 or 3 for 32 bits.
- R8: A write that fails performs no backplane access. It responds with `rsp_err = 1` and `rsp_rdata = 0`, so the target location keeps its old contents.
- R9: If `bus_pwr_ok` is low when a request is accepted, the block responds with an error. It makes no window write and no backplane access, and the recorded core is left unchanged.
- R10: `req_ready` is high only while no request is in flight. Each accepted request produces exactly one single-cycle `rsp_valid`.
- R11: A successful read returns `bus_rdata` masked to the access width, with `rsp_err = 0`. A successful write passes offset, size and data to the backplane and responds with `rsp_err = 0` and `rsp_rdata = 0`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Host request present |
| req_ready | output | 1 | Block can accept a request |
| req_core | input | IDX_W | Target core index |
| req_offset | input | OFF_W | Register offset inside the core window |
| req_size | input | 2 | Access width code (0: 8, 1: 16, 2/3: 32 bits) |
| req_write | input | 1 | 1 for write, 0 for read |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Response strobe, one cycle |
| rsp_rdata | output | 32 | Read data, or all ones at width on failure |
| rsp_err | output | 1 | Access could not be completed |
| bus_pwr_ok | input | 1 | Backplane powered |
| win_wr_en | output | 1 | Window register write strobe |
| win_wr_data | output | ADDR_W | Window base value to write |
| win_rd_data | input | ADDR_W | Current window register contents |
| bus_req | output | 1 | Backplane access strobe |
| bus_write | output | 1 | Backplane access direction |
| bus_size | output | 2 | Backplane access width code |
| bus_offset | output | OFF_W | Offset inside the window |
| bus_wdata | output | 32 | Backplane write data |
| bus_rdata | input | 32 | Backplane read data, valid the cycle after `bus_req` |

## Verification
A wrong recorded core shows in one of two ways. A missing switch sends the access to whichever core the window still shows, so read data comes back with another core's pattern in the same response. A needless switch shows as an extra window write, seen before that response. A faulty retry counter or wait timer changes how many window writes occur and how far apart they are, and this is visible within one request. A bad error path shows in the response that closes the failing request: wrong fill bits, a nonzero write reply, or a backplane strobe where none should happen. Later reads of the untouched location confirm that a dropped write stayed dropped.

// File: rtl/cwa_pkg.sv
package cwa_pkg;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2
  } acc_size_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WIN_WR,
    ST_WIN_CHK,
    ST_WAIT,
    ST_ISSUE,
    ST_CAPT,
    ST_RESP
  } arb_state_e;

  // Ones covering the access width; codes above 2 are treated as full word
  function automatic logic [31:0] lane_ones(input logic [1:0] sz);
    logic [31:0] m;
    case (sz)
      SZ_BYTE: m = 32'h0000_00FF;
      SZ_HALF: m = 32'h0000_FFFF;
      default: m = 32'hFFFF_FFFF;
    endcase
    return m;
  endfunction

endpackage

// File: rtl/cwa_win_codec.sv
// Converts a core index to a window base and decodes the window read-back
module cwa_win_codec #(
  parameter int          ADDR_W    = 32,
  parameter int          IDX_W     = 2,
  parameter int unsigned ENUM_BASE = 32'h1800_0000,
  parameter int unsigned CORE_SPAN = 32'h0000_1000
) (
  input  logic [IDX_W-1:0]  tgt_idx,
  input  logic [ADDR_W-1:0] rb_value,
  output logic [ADDR_W-1:0] base_addr,
  output logic              rb_match
);

  localparam logic [ADDR_W-1:0] BASE_V  = ADDR_W'(ENUM_BASE);
  localparam logic [ADDR_W-1:0] SPAN_V  = ADDR_W'(CORE_SPAN);
  localparam bit                SPAN_P2 = ((CORE_SPAN & (CORE_SPAN - 1)) == 0);
  localparam int                SPAN_SH = $clog2(CORE_SPAN);

  logic [ADDR_W-1:0] tgt_ext;
  logic [ADDR_W-1:0] diff;
  logic [ADDR_W-1:0] quot;
  logic              below;

  assign tgt_ext   = ADDR_W'(tgt_idx);
  assign base_addr = BASE_V + tgt_ext * SPAN_V;
  assign below     = (rb_value < BASE_V);
  assign diff      = rb_value - BASE_V;

  generate
    if (SPAN_P2) begin : g_shift
      assign quot = diff >> SPAN_SH;
    end else begin : g_divide
      assign quot = diff / SPAN_V;
    end
  endgenerate

  assign rb_match = !below && (quot == tgt_ext);

endmodule

// File: rtl/cwa_wait_timer.sv
// Counts the settle delay between window writes while enabled
module cwa_wait_timer #(
  parameter int CLK_MHZ = 125,
  parameter int WAIT_US = 10
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic done
);

  localparam int WAIT_CYC = (CLK_MHZ * WAIT_US < 1) ? 1 : CLK_MHZ * WAIT_US;
  localparam int CNT_W    = (WAIT_CYC < 2) ? 1 : $clog2(WAIT_CYC);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;

  assign done = run && (cnt_q == CNT_W'(WAIT_CYC - 1));

  always_comb begin
    if (!run || done) begin
      cnt_d = '0;
    end else begin
      cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_d;
    end
  end

endmodule

// File: rtl/cwa_retry_count.sv
// Tracks failed verify attempts of one request and flags the give-up point
module cwa_retry_count #(
  parameter int MAX_RETRY = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic inc,
  output logic give_up
);

  localparam int RC_W = $clog2(MAX_RETRY + 3);

  logic [RC_W-1:0] cnt_q;
  logic [RC_W-1:0] cnt_d;
  logic            cnt_en;

  assign give_up = (cnt_q > RC_W'(MAX_RETRY));
  assign cnt_en  = clr || inc;

  always_comb begin
    if (clr) begin
      cnt_d = '0;
    end else begin
      cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

endmodule

// File: rtl/core_window_arbiter.sv
module core_window_arbiter #(
  parameter int          NCORES    = 4,
  parameter int          ADDR_W    = 32,
  parameter int          OFF_W     = 12,
  parameter int unsigned ENUM_BASE = 32'h1800_0000,
  parameter int unsigned CORE_SPAN = 32'h0000_1000,
  parameter int          MAX_RETRY = 2,
  parameter int          CLK_MHZ   = 125,
  parameter int          WAIT_US   = 10,
  localparam int         IDX_W     = (NCORES > 1) ? $clog2(NCORES) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [IDX_W-1:0]  req_core,
  input  logic [OFF_W-1:0]  req_offset,
  input  logic [1:0]        req_size,
  input  logic              req_write,
  input  logic [31:0]       req_wdata,
  output logic              rsp_valid,
  output logic [31:0]       rsp_rdata,
  output logic              rsp_err,
  input  logic              bus_pwr_ok,
  output logic              win_wr_en,
  output logic [ADDR_W-1:0] win_wr_data,
  input  logic [ADDR_W-1:0] win_rd_data,
  output logic              bus_req,
  output logic              bus_write,
  output logic [1:0]        bus_size,
  output logic [OFF_W-1:0]  bus_offset,
  output logic [31:0]       bus_wdata,
  input  logic [31:0]       bus_rdata
);

  import cwa_pkg::*;

  // Reset: asserted asynchronously, released on a clock edge
  logic [1:0] rst_sync_q;
  logic       rst_i_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_sync_q <= 2'b00;
    end else begin
      rst_sync_q <= {rst_sync_q[0], 1'b1};
    end
  end

  assign rst_i_n = rst_sync_q[1];

  // State and captured request
  arb_state_e       st_q, st_d;
  logic [IDX_W-1:0] cur_idx_q;
  logic [OFF_W-1:0] cur_off_q;
  logic [1:0]       cur_size_q;
  logic             cur_we_q;
  logic [31:0]      cur_wdata_q;
  logic             map_vld_q;
  logic [IDX_W-1:0] map_idx_q;
  logic [31:0]      rsp_data_q, rsp_data_d;
  logic             rsp_err_q, rsp_err_d;

  logic ld_req, ld_rsp, map_set, map_clr, rc_clr, rc_inc;
  logic hit, win_match, give_up, wait_run, wait_done;

  assign hit = map_vld_q && (map_idx_q == req_core);

  cwa_win_codec #(
    .ADDR_W    (ADDR_W),
    .IDX_W     (IDX_W),
    .ENUM_BASE (ENUM_BASE),
    .CORE_SPAN (CORE_SPAN)
  ) u_codec (
    .tgt_idx   (cur_idx_q),
    .rb_value  (win_rd_data),
    .base_addr (win_wr_data),
    .rb_match  (win_match)
  );

  assign wait_run = (st_q == ST_WAIT);

  cwa_wait_timer #(
    .CLK_MHZ (CLK_MHZ),
    .WAIT_US (WAIT_US)
  ) u_wait (
    .clk   (clk),
    .rst_n (rst_i_n),
    .run   (wait_run),
    .done  (wait_done)
  );

  cwa_retry_count #(
    .MAX_RETRY (MAX_RETRY)
  ) u_retry (
    .clk     (clk),
    .rst_n   (rst_i_n),
    .clr     (rc_clr),
    .inc     (rc_inc),
    .give_up (give_up)
  );

  // Next-state and datapath control
  always_comb begin
    st_d       = st_q;
    ld_req     = 1'b0;
    ld_rsp     = 1'b0;
    rsp_data_d = '0;
    rsp_err_d  = 1'b0;
    map_set    = 1'b0;
    map_clr    = 1'b0;
    rc_clr     = 1'b0;
    rc_inc     = 1'b0;
    case (st_q)
      ST_IDLE: begin
        if (req_valid) begin
          ld_req = 1'b1;
          rc_clr = 1'b1;
          if (!bus_pwr_ok) begin
            ld_rsp     = 1'b1;
            rsp_err_d  = 1'b1;
            rsp_data_d = req_write ? 32'h0 : lane_ones(req_size);
            st_d       = ST_RESP;
          end else if (hit) begin
            st_d = ST_ISSUE;
          end else begin
            st_d = ST_WIN_WR;
          end
        end
      end
      ST_WIN_WR: st_d = ST_WIN_CHK;
      ST_WIN_CHK: begin
        if (win_match) begin
          map_set = 1'b1;
          st_d    = ST_ISSUE;
        end else if (give_up) begin
          map_clr    = 1'b1;
          ld_rsp     = 1'b1;
          rsp_err_d  = 1'b1;
          rsp_data_d = cur_we_q ? 32'h0 : lane_ones(cur_size_q);
          st_d       = ST_RESP;
        end else begin
          rc_inc = 1'b1;
          st_d   = ST_WAIT;
        end
      end
      ST_WAIT: begin
        if (wait_done) begin
          st_d = ST_WIN_WR;
        end
      end
      ST_ISSUE: st_d = ST_CAPT;
      ST_CAPT: begin
        ld_rsp     = 1'b1;
        rsp_data_d = cur_we_q ? 32'h0 : (bus_rdata & lane_ones(cur_size_q));
        st_d       = ST_RESP;
      end
      ST_RESP: st_d = ST_IDLE;
      default: st_d = ST_IDLE;
    endcase
  end

  // Registers
  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) begin
      st_q <= ST_IDLE;
    end else begin
      st_q <= st_d;
    end
  end

  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) begin
      cur_idx_q   <= '0;
      cur_off_q   <= '0;
      cur_size_q  <= '0;
      cur_we_q    <= 1'b0;
      cur_wdata_q <= '0;
    end else if (ld_req) begin
      cur_idx_q   <= req_core;
      cur_off_q   <= req_offset;
      cur_size_q  <= req_size;
      cur_we_q    <= req_write;
      cur_wdata_q <= req_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) begin
      map_vld_q <= 1'b0;
      map_idx_q <= '0;
    end else if (map_set) begin
      map_vld_q <= 1'b1;
      map_idx_q <= cur_idx_q;
    end else if (map_clr) begin
      map_vld_q <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) begin
      rsp_data_q <= '0;
      rsp_err_q  <= 1'b0;
    end else if (ld_rsp) begin
      rsp_data_q <= rsp_data_d;
      rsp_err_q  <= rsp_err_d;
    end
  end

  // Outputs
  assign req_ready  = (st_q == ST_IDLE);
  assign rsp_valid  = (st_q == ST_RESP);
  assign rsp_rdata  = rsp_data_q;
  assign rsp_err    = rsp_err_q;
  assign win_wr_en  = (st_q == ST_WIN_WR);
  assign bus_req    = (st_q == ST_ISSUE);
  assign bus_write  = cur_we_q;
  assign bus_size   = cur_size_q;
  assign bus_offset = cur_off_q;
  assign bus_wdata  = cur_wdata_q;

endmodule

// File: rtl/cwa_checker.sv
module cwa_checker #(
  parameter int          NCORES    = 4,
  parameter int          ADDR_W    = 32,
  parameter int unsigned ENUM_BASE = 32'h1800_0000,
  parameter int unsigned CORE_SPAN = 32'h0000_1000,
  parameter int          MAX_RETRY = 2,
  parameter int          CLK_MHZ   = 125,
  parameter int          WAIT_US   = 10,
  localparam int         IDX_W     = (NCORES > 1) ? $clog2(NCORES) : 1
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_ready,
  input logic [IDX_W-1:0]  req_core,
  input logic [1:0]        req_size,
  input logic              req_write,
  input logic              rsp_valid,
  input logic [31:0]       rsp_rdata,
  input logic              rsp_err,
  input logic              bus_pwr_ok,
  input logic              win_wr_en,
  input logic [ADDR_W-1:0] win_wr_data,
  input logic [ADDR_W-1:0] win_rd_data,
  input logic              bus_req
);

  localparam int WAIT_CYC = (CLK_MHZ * WAIT_US < 1) ? 1 : CLK_MHZ * WAIT_US;
  localparam int GAP_W    = $clog2(WAIT_CYC + 4);
  localparam int WC_W     = $clog2(MAX_RETRY + 4);
  localparam logic [ADDR_W-1:0] BASE_V = ADDR_W'(ENUM_BASE);
  localparam logic [ADDR_W-1:0] SPAN_V = ADDR_W'(CORE_SPAN);

  logic             accept;
  logic             pend, sh_we, sh_nopwr, sh_hit, bus_seen, wr_seen, ck_vld;
  logic [IDX_W-1:0] sh_idx, ck_idx;
  logic [1:0]       sh_size;
  logic [WC_W-1:0]  wr_cnt;
  logic [GAP_W-1:0] gap;
  logic [31:0]      fail_ones;
  logic [ADDR_W-1:0] rb_idx;

  assign accept    = req_valid && req_ready;
  assign fail_ones = (sh_size == 2'd0) ? 32'h0000_00FF :
                     (sh_size == 2'd1) ? 32'h0000_FFFF : 32'hFFFF_FFFF;
  assign rb_idx    = (win_rd_data - BASE_V) / SPAN_V;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend <= 1'b0; sh_we <= 1'b0; sh_nopwr <= 1'b0; sh_hit <= 1'b0;
      bus_seen <= 1'b0; wr_seen <= 1'b0; ck_vld <= 1'b0;
      sh_idx <= '0; ck_idx <= '0; sh_size <= '0; wr_cnt <= '0; gap <= '0;
    end else begin
      if (accept) begin
        pend     <= 1'b1;
        sh_idx   <= req_core;
        sh_size  <= req_size;
        sh_we    <= req_write;
        sh_nopwr <= !bus_pwr_ok;
        sh_hit   <= ck_vld && (ck_idx == req_core);
        wr_cnt   <= '0;
        bus_seen <= 1'b0;
        wr_seen  <= 1'b0;
        gap      <= '0;
      end else begin
        if (win_wr_en) begin
          wr_cnt  <= wr_cnt + 1'b1;
          wr_seen <= 1'b1;
          gap     <= GAP_W'(1);
        end else if (gap != {GAP_W{1'b1}}) begin
          gap <= gap + 1'b1;
        end
        if (bus_req) bus_seen <= 1'b1;
        if (rsp_valid) begin
          pend <= 1'b0;
          if (!rsp_err) begin
            ck_vld <= 1'b1;
            ck_idx <= sh_idx;
          end else if (!sh_nopwr) begin
            ck_vld <= 1'b0;
          end
        end
      end
    end
  end

  // R1
  win_base_chk: assert property (@(posedge clk) disable iff (!rst_n)
    win_wr_en |-> (win_wr_data == BASE_V + ADDR_W'(sh_idx) * SPAN_V));

  // R2
  first_switch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_err && !sh_hit) |-> (wr_cnt != '0));

  // R3
  hit_no_switch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    win_wr_en |-> !sh_hit);

  // R4
  verified_access_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req |-> ((win_rd_data >= BASE_V) && (rb_idx == ADDR_W'(sh_idx))));

  // R5
  retry_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (win_wr_en && wr_seen) |-> (gap == GAP_W'(WAIT_CYC + 2)));

  // R5
  no_back_to_back_chk: assert property (@(posedge clk) disable iff (!rst_n)
    win_wr_en |=> !win_wr_en);

  // R6
  write_limit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    win_wr_en |-> (wr_cnt < WC_W'(MAX_RETRY + 2)));

  // R6
  give_up_point_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_err && !sh_nopwr) |-> (wr_cnt == WC_W'(MAX_RETRY + 2)));

  // R7
  fail_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_err && !sh_we) |-> (rsp_rdata == fail_ones));

  // R8
  fail_no_access_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_err) |-> !bus_seen);

  // R9
  unpowered_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (win_wr_en || bus_req) |-> !sh_nopwr);

  // R10
  single_flight_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pend |-> !req_ready);

  // R10
  rsp_owned_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> pend);

endmodule

bind core_window_arbiter cwa_checker #(
  .NCORES    (NCORES),
  .ADDR_W    (ADDR_W),
  .ENUM_BASE (ENUM_BASE),
  .CORE_SPAN (CORE_SPAN),
  .MAX_RETRY (MAX_RETRY),
  .CLK_MHZ   (CLK_MHZ),
  .WAIT_US   (WAIT_US)
) u_cwa_checker (
  .clk         (clk),
  .rst_n       (rst_n),
  .req_valid   (req_valid),
  .req_ready   (req_ready),
  .req_core    (req_core),
  .req_size    (req_size),
  .req_write   (req_write),
  .rsp_valid   (rsp_valid),
  .rsp_rdata   (rsp_rdata),
  .rsp_err     (rsp_err),
  .bus_pwr_ok  (bus_pwr_ok),
  .win_wr_en   (win_wr_en),
  .win_wr_data (win_wr_data),
  .win_rd_data (win_rd_data),
  .bus_req     (bus_req)
);

// File: tb/test_core_window_arbiter.sv
module test_core_window_arbiter;

  localparam int          NC     = 4;
  localparam int          AW     = 32;
  localparam int          OW     = 8;
  localparam int unsigned BASE   = 32'h1800_0000;
  localparam int unsigned SPAN   = 32'h0000_1000;
  localparam int          MAXR   = 2;
  localparam int          MHZ    = 1;
  localparam int          WUS    = 10;
  localparam int          WAITC  = MHZ * WUS;
  localparam int          IW     = 2;

  logic          clk, rst_n;
  logic          req_valid, req_ready, req_write;
  logic [IW-1:0] req_core;
  logic [OW-1:0] req_offset;
  logic [1:0]    req_size;
  logic [31:0]   req_wdata;
  logic          rsp_valid, rsp_err;
  logic [31:0]   rsp_rdata;
  logic          bus_pwr_ok;
  logic          win_wr_en;
  logic [AW-1:0] win_wr_data;
  logic [AW-1:0] win_reg;
  logic          bus_req, bus_write;
  logic [1:0]    bus_size;
  logic [OW-1:0] bus_offset;
  logic [31:0]   bus_wdata, bus_rdata;

  int checks, fails, cyc, win_cnt, bus_cnt;
  int corrupt_from, corrupt_n;
  int wr_cyc [0:63];
  logic [31:0] mem [0:NC*16-1];
  logic [31:0] exp_mem [0:NC*16-1];
  bit finished;

  core_window_arbiter #(
    .NCORES(NC), .ADDR_W(AW), .OFF_W(OW), .ENUM_BASE(BASE), .CORE_SPAN(SPAN),
    .MAX_RETRY(MAXR), .CLK_MHZ(MHZ), .WAIT_US(WUS)
  ) i_core_window_arbiter (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_core(req_core), .req_offset(req_offset), .req_size(req_size),
    .req_write(req_write), .req_wdata(req_wdata), .rsp_valid(rsp_valid),
    .rsp_rdata(rsp_rdata), .rsp_err(rsp_err), .bus_pwr_ok(bus_pwr_ok),
    .win_wr_en(win_wr_en), .win_wr_data(win_wr_data), .win_rd_data(win_reg),
    .bus_req(bus_req), .bus_write(bus_write), .bus_size(bus_size),
    .bus_offset(bus_offset), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  function automatic logic [31:0] ones(input int sz);
    if (sz == 0) return 32'h0000_00FF;
    if (sz == 1) return 32'h0000_FFFF;
    return 32'hFFFF_FFFF;
  endfunction

  // Window register and backplane model
  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (!rst_n) begin
      win_reg <= '0;
      win_cnt <= 0;
      bus_cnt <= 0;
      bus_rdata <= '0;
      for (int i = 0; i < NC*16; i++) mem[i] <= 32'h0;
    end else begin
      if (win_wr_en) begin
        if (win_cnt >= corrupt_from && win_cnt < corrupt_from + corrupt_n)
          win_reg <= win_wr_data + SPAN;
        else
          win_reg <= win_wr_data;
        wr_cyc[win_cnt % 64] <= cyc;
        win_cnt <= win_cnt + 1;
      end
      if (bus_req) begin
        bus_cnt <= bus_cnt + 1;
        if (win_reg >= BASE && (win_reg - BASE) / SPAN < NC) begin
          if (bus_write)
            mem[((win_reg - BASE) / SPAN) * 16 + int'(bus_offset[5:2])] <= bus_wdata & ones(int'(bus_size));
          bus_rdata <= mem[((win_reg - BASE) / SPAN) * 16 + int'(bus_offset[5:2])];
        end else begin
          bus_rdata <= 32'hDEAD_BEEF;
        end
      end
    end
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %08h expected %08h", req, act, exp);
    end
  endtask

  task automatic acc(input int c, input int w, input int sz, input bit we,
                     input logic [31:0] wd, output logic [31:0] rd, output bit er);
    int t;
    @(negedge clk);
    chk(req_ready, "R10 ready when idle", {31'b0, req_ready}, 32'h1);
    req_valid = 1'b1; req_core = IW'(c); req_offset = OW'(w * 4);
    req_size = 2'(sz); req_write = we; req_wdata = wd;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    t = 0;
    while (!rsp_valid && t < 2000) begin
      chk(!req_ready, "R10 ready low in flight", {31'b0, req_ready}, 32'h0);
      @(negedge clk);
      t++;
    end
    chk(t < 2000, "R10 response arrives", t, 0);
    rd = rsp_rdata; er = rsp_err;
    @(negedge clk);
    chk(!rsp_valid, "R10 single response strobe", {31'b0, rsp_valid}, 32'h0);
  endtask

  logic [31:0] rd, wd, exp;
  bit er;
  int w0, b0;

  initial begin
    checks = 0; fails = 0; cyc = 0; finished = 0;
    corrupt_from = 0; corrupt_n = 0;
    req_valid = 0; req_core = '0; req_offset = '0; req_size = '0;
    req_write = 0; req_wdata = '0; bus_pwr_ok = 1'b1;
    rst_n = 1'b0;
    repeat (4) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(req_ready && !rsp_valid && !win_wr_en && !bus_req, "R10 reset state",
        {28'b0, req_ready, rsp_valid, win_wr_en, bus_req}, 32'h8);
    for (int i = 0; i < NC*16; i++) exp_mem[i] = 32'h0;

    // R2 R1 R3 R11: sweep cores, words, write sizes, read sizes
    for (int c = 0; c < NC; c++) begin
      for (int w = 0; w < 4; w++) begin
        for (int ws = 0; ws < 3; ws++) begin
          w0 = win_cnt;
          wd = 32'hA5C3_0000 ^ (c << 20) ^ (w << 12) ^ (ws << 4) ^ 32'h0000_9E17;
          acc(c, w, ws, 1'b1, wd, rd, er);
          exp_mem[c*16+w] = wd & ones(ws);
          if (w == 0 && ws == 0) begin
            chk(win_cnt - w0 == 1, "R2 one window write on new core", win_cnt - w0, 1);
            chk(win_reg == BASE + c * SPAN, "R1 window base value", win_reg, BASE + c * SPAN);
          end else begin
            chk(win_cnt == w0, "R3 no switch on mapped core", win_cnt - w0, 0);
          end
          chk(!er && rd == 0, "R11 write response", rd, 0);
          for (int rs = 0; rs < 4; rs++) begin
            acc(c, w, rs, 1'b0, 32'h0, rd, er);
            exp = exp_mem[c*16+w] & ones(rs);
            chk(!er && rd == exp, "R11 read data at width", rd, exp);
          end
        end
      end
    end

    // R3: alternate cores, each change switches once
    for (int k = 0; k < 6; k++) begin
      w0 = win_cnt;
      acc(k % 2 + 1, 1, 2, 1'b0, 32'h0, rd, er);
      chk(win_cnt - w0 == 1, "R3 switch on changed core", win_cnt - w0, 1);
      chk(!er && rd == exp_mem[(k % 2 + 1)*16+1], "R3 data from new core", rd, exp_mem[(k % 2 + 1)*16+1]);
    end

    // R4 R5: one bad read-back then success
    w0 = win_cnt; corrupt_from = win_cnt; corrupt_n = 1;
    acc(3, 2, 2, 1'b0, 32'h0, rd, er);
    chk(win_cnt - w0 == 2, "R4 rewrite after mismatch", win_cnt - w0, 2);
    chk(wr_cyc[(w0 + 1) % 64] - wr_cyc[w0 % 64] == WAITC + 2, "R5 retry spacing",
        wr_cyc[(w0 + 1) % 64] - wr_cyc[w0 % 64], WAITC + 2);
    chk(!er && rd == exp_mem[3*16+2], "R4 data after verified switch", rd, exp_mem[3*16+2]);

    // R6 boundary: MAXR+1 bad read-backs still succeed
    w0 = win_cnt; corrupt_from = win_cnt; corrupt_n = MAXR + 1;
    acc(0, 3, 1, 1'b0, 32'h0, rd, er);
    chk(win_cnt - w0 == MAXR + 2, "R6 last attempt succeeds", win_cnt - w0, MAXR + 2);
    chk(!er && rd == (exp_mem[3] & ones(1)), "R6 data after late success", rd, exp_mem[3] & ones(1));
    for (int k = 1; k < MAXR + 2; k++)
      chk(wr_cyc[(w0 + k) % 64] - wr_cyc[(w0 + k - 1) % 64] == WAITC + 2, "R5 spacing every retry",
          wr_cyc[(w0 + k) % 64] - wr_cyc[(w0 + k - 1) % 64], WAITC + 2);

    // R6 R7: exhausted retries for each read width
    for (int rs = 0; rs < 3; rs++) begin
      w0 = win_cnt; b0 = bus_cnt; corrupt_from = win_cnt; corrupt_n = MAXR + 2;
      acc(1 + rs, 0, rs, 1'b0, 32'h0, rd, er);
      chk(win_cnt - w0 == MAXR + 2, "R6 write limit", win_cnt - w0, MAXR + 2);
      chk(er, "R6 error flag", {31'b0, er}, 32'h1);
      chk(rd == ones(rs), "R7 all ones at width", rd, ones(rs));
      chk(bus_cnt == b0, "R7 no backplane access", bus_cnt - b0, 0);
    end

    // R6: failed switch clears the record; next access to same core switches
    corrupt_n = 0;
    w0 = win_cnt;
    acc(3, 0, 2, 1'b0, 32'h0, rd, er);
    chk(win_cnt - w0 == 1, "R6 record cleared after give-up", win_cnt - w0, 1);
    chk(!er && rd == exp_mem[3*16], "R6 recovery read", rd, exp_mem[3*16]);

    // R8: failed write dropped
    w0 = win_cnt; b0 = bus_cnt; corrupt_from = win_cnt; corrupt_n = MAXR + 2;
    acc(2, 2, 2, 1'b1, 32'h1234_5678, rd, er);
    chk(er && rd == 0, "R8 failed write response", rd, 0);
    chk(bus_cnt == b0, "R8 no backplane write", bus_cnt - b0, 0);
    corrupt_n = 0;
    acc(2, 2, 2, 1'b0, 32'h0, rd, er);
    chk(!er && rd == exp_mem[2*16+2], "R8 location unchanged", rd, exp_mem[2*16+2]);

    // R9: unpowered requests
    bus_pwr_ok = 1'b0;
    w0 = win_cnt; b0 = bus_cnt;
    acc(0, 1, 1, 1'b0, 32'h0, rd, er);
    chk(er && rd == ones(1), "R9 unpowered read fills ones", rd, ones(1));
    acc(1, 1, 2, 1'b1, 32'hFACE_0FF0, rd, er);
    chk(er && rd == 0, "R9 unpowered write rejected", rd, 0);
    chk(win_cnt == w0 && bus_cnt == b0, "R9 no window or bus activity",
        (win_cnt - w0) + (bus_cnt - b0), 0);
    bus_pwr_ok = 1'b1;
    w0 = win_cnt;
    acc(2, 1, 2, 1'b0, 32'h0, rd, er);
    chk(win_cnt == w0, "R9 record kept across unpowered requests", win_cnt - w0, 0);
    acc(1, 1, 2, 1'b0, 32'h0, rd, er);
    chk(!er && rd == exp_mem[1*16+1], "R9 unpowered write dropped", rd, exp_mem[1*16+1]);

    // R4: read-back below base is a mismatch
    w0 = win_cnt;
    force win_reg = BASE - 32'h10;
    @(negedge clk);
    req_valid = 1'b1; req_core = 2'd0; req_offset = '0; req_size = 2'd2; req_write = 1'b0;
    @(posedge clk); @(negedge clk); req_valid = 1'b0;
    for (int t = 0; t < 2000 && !rsp_valid; t++) @(negedge clk);
    chk(rsp_err && rsp_rdata == 32'hFFFF_FFFF, "R4 below-base read-back rejected", rsp_rdata, 32'hFFFF_FFFF);
    @(negedge clk);
    release win_reg;

    if (!finished) begin
      finished = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++; fails++;
      $display("FAIL R10 watchdog expired: actual hang expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

endmodule